// File: doc/BRIEF.md
# Receive MAC Address Filter

This block sits behind the receive demodulator of a 2.4 GHz low-rate wireless transceiver. Once a valid PHY header has been seen, it parses the MAC header of the arriving IEEE 802.15.4 frame byte by byte. It decodes the frame control field and then compares the destination PAN identifier and the destination address against locally configured values. Depending on the destination addressing mode, that address is either the 16-bit short address or the 64-bit extended address.

When every destination field agrees with the configuration, the filter emits a one-cycle address-match pulse and sets a filter-pass flag. It also decides whether the end-of-frame event reaches the rest of the chip. In extended mode the event is let through only for frames that pass the filter and carry a good FCS. Promiscuous mode lets every frame end through, even one with a bad FCS. Basic mode never suppresses the event, although matching is still reported. CRC computation happens upstream; the block only consumes its verdict.

Top module: `rx_mac_addr_filter`

## Requirements
- R1: After reset, addr_match_o, frame_end_o, filter_pass_o, fcf_valid_o and all decoded frame control outputs are 0.
- R2: Byte 0 after frame_start_i gives frame_type_o = bits [2:0] and ack_req_o = bit 5. Byte 1 gives dst_mode_o = bits [3:2] and src_mode_o = bits [7:6]. All four outputs and fcf_valid_o update in the cycle after byte 1 is accepted, and they are cleared in the cycle after frame_start_i. Byte 2 (sequence number) is not compared.
- R3: addr_match_o is a single-cycle pulse, high in the cycle after the last destination address byte is accepted, when all destination fields match.
- R4: For dst_mode 2, bytes 3-4 are the destination PAN and bytes 5-6 are the short address. For dst_mode 3, bytes 3-4 are the PAN and bytes 5-12 are the extended address. Every field is least significant byte first. For dst_mode 0 or 1 no match is ever raised.
- R5: A destination PAN identifier of 0xFFFF matches any configured PAN, and a short address of 0xFFFF matches any configured short address.
- R6: A mismatch in any single byte of a compared field prevents the match, whatever the following bytes hold.
- R7: filter_pass_o rises together with addr_match_o and holds until the cycle after the next frame_start_i, when it is 0.
- R8: With ext_mode_i=1 and promisc_i=0, frame_end_o pulses in the cycle after frame_end_i only if filter_pass_o and fcs_ok_i are both 1.
- R9: With ext_mode_i=1 and promisc_i=1, frame_end_o pulses in the cycle after every frame_end_i, regardless of the FCS or the filter result.
- R10: With ext_mode_i=0 (basic), frame_end_o pulses in the cycle after every frame_end_i, while the filter still drives addr_match_o and filter_pass_o.
- R11: Bytes offered after frame_end_i and before the next frame_start_i change no output.
- R12: A frame that ends before its last destination address byte raises no match, so in extended non-promiscuous mode its end is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Pulse: valid PHY header detected, MAC bytes follow |
| byte_valid_i | input | 1 | byte_i carries a received MAC byte |
| byte_i | input | 8 | Received byte, over-the-air order |
| frame_end_i | input | 1 | Pulse after the last byte of the frame |
| fcs_ok_i | input | 1 | FCS verdict, valid with frame_end_i |
| ext_mode_i | input | 1 | 1: extended mode with end gating, 0: basic mode |
| promisc_i | input | 1 | Promiscuous: let every frame end through |
| cfg_pan_id_i | input | PAN_W | Configured PAN identifier |
| cfg_short_addr_i | input | SADDR_W | Configured short address |
| cfg_ext_addr_i | input | EADDR_W | Configured extended address |
| addr_match_o | output | 1 | Single-cycle address-match event |
| frame_end_o | output | 1 | Gated end-of-frame event |
| filter_pass_o | output | 1 | Current frame passed the address filter |
| fcf_valid_o | output | 1 | Frame control outputs are valid |
| frame_type_o | output | 3 | Decoded frame type |
| ack_req_o | output | 1 | Acknowledgement requested |
| dst_mode_o | output | 2 | Destination addressing mode |
| src_mode_o | output | 2 | Source addressing mode |

## Verification
A byte counter that is off by one shifts every field. The address-match pulse then arrives one cycle early or late, or not at all, and the decoded frame control outputs show the wrong bits one cycle after byte 1. A mismatch latch that is not held, or not cleared at frame start, lets a frame with a bad low byte pass. It can also block the next good frame. Either fault shows at filter_pass_o and addr_match_o as the last address byte is accepted, and again at frame_end_o one cycle after frame_end_i in extended mode. A wrong gating term shows only at frame_end_o, in the cycle after frame_end_i, for the mode and FCS combination that exercises it.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;

  localparam int FCF_BYTES = 2;
  localparam int SEQ_BYTES = 1;
  localparam logic [7:0] BCAST_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    AM_NONE  = 2'd0,
    AM_RSVD  = 2'd1,
    AM_SHORT = 2'd2,
    AM_EXT   = 2'd3
  } addr_mode_e;

  typedef struct packed {
    logic [2:0] frame_type;
    logic       ack_req;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
  } fcf_t;

endpackage

// File: rtl/rx_hdr_parser.sv
module rx_hdr_parser
  import rx_filt_pkg::*;
#(
  parameter int PAN_B = 2,
  parameter int SA_B  = 2,
  parameter int EA_B  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  output fcf_t             fcf_o,
  output logic             fcf_vld_o,
  output logic             pan_stb_o,
  output logic [IDX_W-1:0] pan_idx_o,
  output logic             addr_stb_o,
  output logic [IDX_W-1:0] addr_idx_o,
  output logic             addr_last_o
);

  localparam int PAN_OFS  = FCF_BYTES + SEQ_BYTES;
  localparam int ADDR_OFS = PAN_OFS + PAN_B;
  localparam int LONG_B   = (SA_B > EA_B) ? SA_B : EA_B;
  localparam int CNT_MAX  = ADDR_OFS + LONG_B;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       lo_type_q;
  logic             lo_ack_q;
  fcf_t             fcf_q;
  logic             fcf_vld_q;

  int unsigned pos;
  int unsigned addr_len;
  logic        take;
  logic        has_dst;
  logic        unused_fcf_bit;

  assign pos            = 32'(cnt_q);
  assign take           = byte_vld_i && active_q;
  assign has_dst        = fcf_vld_q && fcf_q.dst_mode[1];
  assign unused_fcf_bit = byte_i[4];

  always_comb begin
    unique case (fcf_q.dst_mode)
      AM_SHORT: addr_len = SA_B;
      AM_EXT:   addr_len = EA_B;
      default:  addr_len = 0;
    endcase
  end

  assign pan_stb_o   = take && has_dst && (pos >= PAN_OFS) && (pos < ADDR_OFS);
  assign addr_stb_o  = take && has_dst && (pos >= ADDR_OFS) && (pos < ADDR_OFS + addr_len);
  assign addr_last_o = addr_stb_o && (pos == ADDR_OFS + addr_len - 1);
  assign pan_idx_o   = IDX_W'(pos - PAN_OFS);
  assign addr_idx_o  = IDX_W'(pos - ADDR_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      cnt_q     <= '0;
      lo_type_q <= '0;
      lo_ack_q  <= 1'b0;
      fcf_q     <= '0;
      fcf_vld_q <= 1'b0;
    end else if (start_i) begin
      active_q  <= 1'b1;
      cnt_q     <= '0;
      fcf_q     <= '0;
      fcf_vld_q <= 1'b0;
    end else begin
      if (end_i) active_q <= 1'b0;
      if (take) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
        if (pos == 0) begin
          lo_type_q <= byte_i[2:0];
          lo_ack_q  <= byte_i[5];
        end
        if (pos == 1) begin
          fcf_q.frame_type <= lo_type_q;
          fcf_q.ack_req    <= lo_ack_q;
          fcf_q.dst_mode   <= addr_mode_e'(byte_i[3:2]);
          fcf_q.src_mode   <= addr_mode_e'(byte_i[7:6]);
          fcf_vld_q        <= 1'b1;
        end
      end
    end
  end

  assign fcf_o     = fcf_q;
  assign fcf_vld_o = fcf_vld_q;

endmodule

// File: rtl/rx_addr_cmp.sv
module rx_addr_cmp
  import rx_filt_pkg::*;
#(
  parameter int PAN_B = 2,
  parameter int SA_B  = 2,
  parameter int EA_B  = 8,
  parameter int IDX_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [7:0]         byte_i,
  input  logic               pan_stb_i,
  input  logic [IDX_W-1:0]   pan_idx_i,
  input  logic               addr_stb_i,
  input  logic [IDX_W-1:0]   addr_idx_i,
  input  logic               addr_last_i,
  input  logic               dst_ext_i,
  input  logic [PAN_B*8-1:0] cfg_pan_i,
  input  logic [SA_B*8-1:0]  cfg_sa_i,
  input  logic [EA_B*8-1:0]  cfg_ea_i,
  output logic               match_o,
  output logic               pass_o
);

  logic [PAN_B-1:0] pan_sel, pan_ne_b;
  logic [SA_B-1:0]  sa_sel, sa_ne_b;
  logic [EA_B-1:0]  ea_sel, ea_ne_b;

  for (genvar g = 0; g < PAN_B; g++) begin : g_pan
    assign pan_sel[g]  = (pan_idx_i == IDX_W'(g));
    assign pan_ne_b[g] = (byte_i != cfg_pan_i[g*8 +: 8]);
  end
  for (genvar g = 0; g < SA_B; g++) begin : g_sa
    assign sa_sel[g]  = (addr_idx_i == IDX_W'(g));
    assign sa_ne_b[g] = (byte_i != cfg_sa_i[g*8 +: 8]);
  end
  for (genvar g = 0; g < EA_B; g++) begin : g_ea
    assign ea_sel[g]  = (addr_idx_i == IDX_W'(g));
    assign ea_ne_b[g] = (byte_i != cfg_ea_i[g*8 +: 8]);
  end

  // sticky mismatch flags: *_ne against config, *_nb against broadcast
  logic pan_ne_q, pan_nb_q, sa_ne_q, sa_nb_q, ea_ne_q;
  logic match_q, pass_q;

  logic not_bcast, sa_stb, ea_stb;
  logic pan_ne_now, sa_ne_now, ea_ne_now;
  logic pan_ok, sa_ok, ea_ok, match_now;

  assign not_bcast  = (byte_i != BCAST_BYTE);
  assign sa_stb     = addr_stb_i && !dst_ext_i;
  assign ea_stb     = addr_stb_i && dst_ext_i;
  assign pan_ne_now = pan_stb_i && |(pan_sel & pan_ne_b);
  assign sa_ne_now  = sa_stb && |(sa_sel & sa_ne_b);
  assign ea_ne_now  = ea_stb && |(ea_sel & ea_ne_b);

  assign pan_ok    = !pan_ne_q || !pan_nb_q;
  assign sa_ok     = !(sa_ne_q || sa_ne_now) || !(sa_nb_q || not_bcast);
  assign ea_ok     = !(ea_ne_q || ea_ne_now);
  assign match_now = addr_last_i && pan_ok && (dst_ext_i ? ea_ok : sa_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pan_ne_q <= 1'b0;
      pan_nb_q <= 1'b0;
      sa_ne_q  <= 1'b0;
      sa_nb_q  <= 1'b0;
      ea_ne_q  <= 1'b0;
      match_q  <= 1'b0;
      pass_q   <= 1'b0;
    end else if (clear_i) begin
      pan_ne_q <= 1'b0;
      pan_nb_q <= 1'b0;
      sa_ne_q  <= 1'b0;
      sa_nb_q  <= 1'b0;
      ea_ne_q  <= 1'b0;
      match_q  <= 1'b0;
      pass_q   <= 1'b0;
    end else begin
      if (pan_ne_now)             pan_ne_q <= 1'b1;
      if (pan_stb_i && not_bcast) pan_nb_q <= 1'b1;
      if (sa_ne_now)              sa_ne_q  <= 1'b1;
      if (sa_stb && not_bcast)    sa_nb_q  <= 1'b1;
      if (ea_ne_now)              ea_ne_q  <= 1'b1;
      match_q <= match_now;
      if (match_now) pass_q <= 1'b1;
    end
  end

  assign match_o = match_q;
  assign pass_o  = pass_q;

endmodule

// File: rtl/rx_end_gate.sv
module rx_end_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic end_i,
  input  logic fcs_ok_i,
  input  logic pass_i,
  input  logic ext_mode_i,
  input  logic promisc_i,
  output logic end_o
);

  logic allow;
  logic end_q;

  // basic: never gated; promiscuous: ignores FCS and filter
  assign allow = !ext_mode_i || promisc_i || (pass_i && fcs_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) end_q <= 1'b0;
    else         end_q <= end_i && allow;
  end

  assign end_o = end_q;

endmodule

// File: rtl/rx_mac_addr_filter.sv
module rx_mac_addr_filter
  import rx_filt_pkg::*;
#(
  parameter int PAN_W   = 16,
  parameter int SADDR_W = 16,
  parameter int EADDR_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_start_i,
  input  logic               byte_valid_i,
  input  logic [7:0]         byte_i,
  input  logic               frame_end_i,
  input  logic               fcs_ok_i,
  input  logic               ext_mode_i,
  input  logic               promisc_i,
  input  logic [PAN_W-1:0]   cfg_pan_id_i,
  input  logic [SADDR_W-1:0] cfg_short_addr_i,
  input  logic [EADDR_W-1:0] cfg_ext_addr_i,
  output logic               addr_match_o,
  output logic               frame_end_o,
  output logic               filter_pass_o,
  output logic               fcf_valid_o,
  output logic [2:0]         frame_type_o,
  output logic               ack_req_o,
  output logic [1:0]         dst_mode_o,
  output logic [1:0]         src_mode_o
);

  localparam int PAN_B  = PAN_W / 8;
  localparam int SA_B   = SADDR_W / 8;
  localparam int EA_B   = EADDR_W / 8;
  localparam int MAX_B  = (PAN_B > SA_B) ? ((PAN_B > EA_B) ? PAN_B : EA_B)
                                         : ((SA_B > EA_B) ? SA_B : EA_B);
  localparam int IDX_W  = (MAX_B > 2) ? $clog2(MAX_B) : 1;

  fcf_t             fcf;
  logic             pan_stb, addr_stb, addr_last;
  logic [IDX_W-1:0] pan_idx, addr_idx;
  logic             pass;

  rx_hdr_parser #(
    .PAN_B(PAN_B), .SA_B(SA_B), .EA_B(EA_B), .IDX_W(IDX_W)
  ) u_parser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (frame_start_i),
    .end_i      (frame_end_i),
    .byte_vld_i (byte_valid_i),
    .byte_i     (byte_i),
    .fcf_o      (fcf),
    .fcf_vld_o  (fcf_valid_o),
    .pan_stb_o  (pan_stb),
    .pan_idx_o  (pan_idx),
    .addr_stb_o (addr_stb),
    .addr_idx_o (addr_idx),
    .addr_last_o(addr_last)
  );

  rx_addr_cmp #(
    .PAN_B(PAN_B), .SA_B(SA_B), .EA_B(EA_B), .IDX_W(IDX_W)
  ) u_cmp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (frame_start_i),
    .byte_i     (byte_i),
    .pan_stb_i  (pan_stb),
    .pan_idx_i  (pan_idx),
    .addr_stb_i (addr_stb),
    .addr_idx_i (addr_idx),
    .addr_last_i(addr_last),
    .dst_ext_i  (fcf.dst_mode == AM_EXT),
    .cfg_pan_i  (cfg_pan_id_i),
    .cfg_sa_i   (cfg_short_addr_i),
    .cfg_ea_i   (cfg_ext_addr_i),
    .match_o    (addr_match_o),
    .pass_o     (pass)
  );

  rx_end_gate u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .end_i     (frame_end_i),
    .fcs_ok_i  (fcs_ok_i),
    .pass_i    (pass),
    .ext_mode_i(ext_mode_i),
    .promisc_i (promisc_i),
    .end_o     (frame_end_o)
  );

  assign filter_pass_o = pass;
  assign frame_type_o  = fcf.frame_type;
  assign ack_req_o     = fcf.ack_req;
  assign dst_mode_o    = fcf.dst_mode;
  assign src_mode_o    = fcf.src_mode;

endmodule

// File: rtl/rx_mac_addr_filter_chk.sv
module rx_mac_addr_filter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_start_i,
  input logic frame_end_i,
  input logic fcs_ok_i,
  input logic ext_mode_i,
  input logic promisc_i,
  input logic addr_match_o,
  input logic frame_end_o,
  input logic filter_pass_o,
  input logic fcf_valid_o
);

  a_r3_match_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |=> !addr_match_o);

  a_r7_match_sets_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_o |-> filter_pass_o);

  a_r7_start_clears_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !filter_pass_o);

  a_r2_start_clears_fcf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> !fcf_valid_o);

  a_r8_ext_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && ext_mode_i && !promisc_i && !(filter_pass_o && fcs_ok_i)) |=> !frame_end_o);

  a_r8_end_needs_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end_i |=> !frame_end_o);

  a_r9_promisc_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && ext_mode_i && promisc_i) |=> frame_end_o);

  a_r10_basic_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_i && !ext_mode_i) |=> frame_end_o);

endmodule

bind rx_mac_addr_filter rx_mac_addr_filter_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .frame_end_i  (frame_end_i),
  .fcs_ok_i     (fcs_ok_i),
  .ext_mode_i   (ext_mode_i),
  .promisc_i    (promisc_i),
  .addr_match_o (addr_match_o),
  .frame_end_o  (frame_end_o),
  .filter_pass_o(filter_pass_o),
  .fcf_valid_o  (fcf_valid_o)
);

// File: tb/rx_mac_addr_filter_tb.sv
module rx_mac_addr_filter_tb_top;

  typedef logic [7:0] bq_t[$];

  localparam logic [15:0] CFG_PAN = 16'h1234;
  localparam logic [15:0] CFG_SA  = 16'hBEEF;
  localparam logic [63:0] CFG_EA  = 64'h0011_2233_4455_6677;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0, byte_vld = 1'b0, frame_end = 1'b0, fcs_ok = 1'b0;
  logic       ext_mode = 1'b1, promisc = 1'b0;
  logic [7:0] byte_d = 8'h00;

  logic       addr_match, frame_end_out, filter_pass, fcf_valid, ack_req;
  logic [2:0] frame_type;
  logic [1:0] dst_mode, src_mode;

  rx_mac_addr_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(frame_start), .byte_valid_i(byte_vld),
    .byte_i(byte_d), .frame_end_i(frame_end), .fcs_ok_i(fcs_ok), .ext_mode_i(ext_mode),
    .promisc_i(promisc), .cfg_pan_id_i(CFG_PAN), .cfg_short_addr_i(CFG_SA),
    .cfg_ext_addr_i(CFG_EA), .addr_match_o(addr_match), .frame_end_o(frame_end_out),
    .filter_pass_o(filter_pass), .fcf_valid_o(fcf_valid), .frame_type_o(frame_type),
    .ack_req_o(ack_req), .dst_mode_o(dst_mode), .src_mode_o(src_mode)
  );

  int checks = 0, errors = 0;
  int n_match = 0, n_end = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  bq_t  q;
  bit   in_f, e_match, e_end, e_pass, e_fv, e_ack;
  bit [2:0] e_type;
  bit [1:0] e_dm, e_sm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); in_f = 0; e_match = 0; e_end = 0; e_pass = 0;
      e_fv = 0; e_ack = 0; e_type = 0; e_dm = 0; e_sm = 0;
    end else begin
      e_match = 0;
      e_end   = 0;
      if (frame_end) begin
        e_end = !ext_mode || promisc || (e_pass && fcs_ok);
        in_f  = 0;
      end
      if (frame_start) begin
        q.delete(); in_f = 1; e_pass = 0; e_fv = 0;
        e_type = 0; e_ack = 0; e_dm = 0; e_sm = 0;
      end else if (byte_vld && in_f) begin
        int n, alen;
        bit ok;
        q.push_back(byte_d);
        n = q.size();
        if (n == 2) begin
          e_type = q[0][2:0]; e_ack = q[0][5];
          e_dm = q[1][3:2]; e_sm = q[1][7:6]; e_fv = 1;
        end
        if (e_fv && e_dm >= 2) begin
          alen = (e_dm == 3) ? 8 : 2;
          if (n == 5 + alen) begin
            bit [15:0] pan, sa;
            bit [63:0] ea;
            pan = {q[4], q[3]};
            ok  = (pan == CFG_PAN) || (pan == 16'hFFFF);
            if (alen == 2) begin
              sa = {q[6], q[5]};
              ok = ok && ((sa == CFG_SA) || (sa == 16'hFFFF));
            end else begin
              for (int i = 0; i < 8; i++) ea[i*8 +: 8] = q[5+i];
              ok = ok && (ea == CFG_EA);
            end
            if (ok) begin e_match = 1; e_pass = 1; end
          end
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string lab;
      lab = !ext_mode ? "R10 frame_end_o" : (promisc ? "R9 frame_end_o" : "R8 frame_end_o");
      chk("R3 addr_match_o", addr_match, e_match);
      chk(lab, frame_end_out, e_end);
      chk("R7 filter_pass_o", filter_pass, e_pass);
      chk("R2 fcf_valid_o", fcf_valid, e_fv);
      chk("R2 fcf fields", {frame_type, ack_req, dst_mode, src_mode}, {e_type, e_ack, e_dm, e_sm});
      if (addr_match) n_match++;
      if (frame_end_out) n_end++;
    end
  end

  function automatic bq_t mk_short(input logic [2:0] ft, input logic ack,
                                   input logic [15:0] pan, input logic [15:0] sa);
    bq_t f;
    f.push_back({2'b00, ack, 2'b00, ft});
    f.push_back(8'h88);
    f.push_back(8'h5A);
    f.push_back(pan[7:0]); f.push_back(pan[15:8]);
    f.push_back(sa[7:0]);  f.push_back(sa[15:8]);
    f.push_back(8'hC3);    f.push_back(8'h3C);
    return f;
  endfunction

  function automatic bq_t mk_ext(input logic [15:0] pan, input logic [63:0] ea);
    bq_t f;
    f.push_back(8'h21);
    f.push_back(8'hCC);
    f.push_back(8'h07);
    f.push_back(pan[7:0]); f.push_back(pan[15:8]);
    for (int i = 0; i < 8; i++) f.push_back(ea[i*8 +: 8]);
    f.push_back(8'h99);
    return f;
  endfunction

  task automatic send_frame(input bq_t f, input logic fcs);
    n_match = 0;
    n_end   = 0;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    foreach (f[i]) begin
      byte_vld = 1'b1; byte_d = f[i];
      @(negedge clk);
    end
    byte_vld = 1'b0;
    frame_end = 1'b1; fcs_ok = fcs;
    @(negedge clk); frame_end = 1'b0; fcs_ok = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bq_t f;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {addr_match, frame_end_out, filter_pass, fcf_valid,
                             frame_type, ack_req, dst_mode, src_mode}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 outputs after release", {addr_match, frame_end_out, filter_pass, fcf_valid}, 0);

    // extended mode, short address match
    send_frame(mk_short(3'd1, 1'b1, CFG_PAN, CFG_SA), 1'b1);
    chk("R3 match count", n_match, 1);
    chk("R8 end with pass and good fcs", n_end, 1);
    chk("R2 fcf decode", {frame_type, ack_req, dst_mode, src_mode}, {3'd1, 1'b1, 2'd2, 2'd2});
    chk("R7 pass held after frame", filter_pass, 1);

    // R11: stray bytes with no frame start
    f = mk_short(3'd3, 1'b0, CFG_PAN, CFG_SA);
    n_match = 0;
    foreach (f[i]) begin
      @(negedge clk); byte_vld = 1'b1; byte_d = f[i];
    end
    @(negedge clk); byte_vld = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 no match from stray bytes", n_match, 0);
    chk("R11 frame type unchanged", frame_type, 3'd1);
    chk("R11 pass unchanged", filter_pass, 1);

    // R7: start clears pass
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk("R7 pass cleared by start", filter_pass, 0);
    chk("R2 fcf_valid cleared by start", fcf_valid, 0);
    frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    repeat (2) @(negedge clk);

    send_frame(mk_short(3'd1, 1'b1, CFG_PAN, CFG_SA), 1'b0);
    chk("R3 match despite bad fcs", n_match, 1);
    chk("R8 end suppressed on bad fcs", n_end, 0);

    send_frame(mk_short(3'd1, 1'b0, CFG_PAN, 16'hBEEE), 1'b1);
    chk("R6 short low byte mismatch", n_match, 0);
    chk("R8 end suppressed on no match", n_end, 0);

    send_frame(mk_short(3'd1, 1'b0, 16'h1235, CFG_SA), 1'b1);
    chk("R6 pan low byte mismatch", n_match, 0);

    send_frame(mk_short(3'd1, 1'b0, 16'hFFFF, 16'hFFFF), 1'b1);
    chk("R5 full broadcast match", n_match, 1);
    chk("R5 broadcast end", n_end, 1);

    send_frame(mk_short(3'd1, 1'b0, CFG_PAN, 16'hFFFF), 1'b1);
    chk("R5 short broadcast match", n_match, 1);

    send_frame(mk_short(3'd1, 1'b0, 16'hFFFF, 16'h00FF), 1'b1);
    chk("R5 partial broadcast is no match", n_match, 0);

    send_frame(mk_ext(CFG_PAN, CFG_EA), 1'b1);
    chk("R4 extended address match", n_match, 1);
    chk("R2 extended dst mode", dst_mode, 2'd3);

    send_frame(mk_ext(CFG_PAN, CFG_EA ^ 64'h8000_0000_0000_0000), 1'b1);
    chk("R6 extended last byte mismatch", n_match, 0);

    send_frame(mk_ext(CFG_PAN, CFG_EA ^ 64'h0000_0000_0000_0001), 1'b1);
    chk("R6 extended first byte mismatch", n_match, 0);

    f = mk_short(3'd1, 1'b0, CFG_PAN, CFG_SA);
    f[1] = 8'h80;
    send_frame(f, 1'b1);
    chk("R4 no destination, no match", n_match, 0);

    f = mk_short(3'd1, 1'b0, CFG_PAN, CFG_SA);
    while (f.size() > 6) void'(f.pop_back());
    send_frame(f, 1'b1);
    chk("R12 truncated frame no match", n_match, 0);
    chk("R12 truncated frame end suppressed", n_end, 0);

    promisc = 1'b1;
    send_frame(mk_short(3'd1, 1'b0, 16'h4321, 16'h0001), 1'b0);
    chk("R9 promiscuous end on bad fcs", n_end, 1);
    chk("R9 promiscuous no match", n_match, 0);
    promisc = 1'b0;

    ext_mode = 1'b0;
    send_frame(mk_short(3'd1, 1'b0, 16'h4321, 16'h0001), 1'b0);
    chk("R10 basic end ungated", n_end, 1);
    chk("R10 basic no match", n_match, 0);
    send_frame(mk_short(3'd1, 1'b0, CFG_PAN, CFG_SA), 1'b0);
    chk("R10 basic still reports match", n_match, 1);
    chk("R10 basic end on bad fcs", n_end, 1);

    finish_run();
  end

endmodule